// File: doc/BRIEF.md
# MDIO Management Interface Master

This block runs single read and write transactions on the two-wire PHY management bus. A request carries a 5-bit PHY address, a 5-bit register address, a direction flag and, for writes, 16 bits of data. The block is accepted only while it is idle. It then produces the management clock and drives the data line through an output value and an output-enable. For reads it samples the returned bits and presents the 16-bit result together with a one-cycle done pulse. The tristate pad lies outside the block, as do the meaning of PHY registers and any link-negotiation sequencing.

The controller has these states. `ST_IDLE` waits for a request. `ST_PREAMBLE` sends 33 ones. `ST_HEADER` sends the 16-bit read header. `ST_CAPTURE` releases the line and samples 19 bits. `ST_FRAME` sends the 32-bit write frame. `ST_DONE` raises done for one cycle. It has these transitions. IDLE→PREAMBLE fires on an accepted request. PREAMBLE→HEADER fires after 33 bits of a read, and PREAMBLE→FRAME after 33 bits of a write. HEADER→CAPTURE fires after 16 bits. CAPTURE→DONE fires after 19 bits and FRAME→DONE after 32 bits. DONE→IDLE always follows one cycle later.

Each bit on the wire lasts `2*DIV_HALF` system cycles: `DIV_HALF` cycles with the clock low, then `DIV_HALF` cycles with it high. With a 125 MHz system clock the default of 25 gives exactly 2.5 MHz, which is the highest rate the bus permits.

Top module: `mdio_master`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`, `done`, `mdc`, `mdio_oe`, `mdio_o` and `rd_data` are all 0.
- R2: A request with `req_valid` high is accepted on a clock edge only when the block is idle. All of its fields are latched at that edge, and `busy` is high from the next cycle. Requests presented while `busy` is high, including the done cycle, are ignored and have no effect on the transaction in progress.
- R3: Counting from the cycle after acceptance, each bit occupies `DIV_HALF` cycles with `mdc` low followed by `DIV_HALF` cycles with `mdc` high.
- R4: Every transaction begins with 33 bits during which `mdio_oe`=1 and `mdio_o`=1.
- R5: A read then sends 16 bits, most significant first, with `mdio_oe`=1: 1,1,0,1,1,0, then PHY address bits 4..0, then register address bits 4..0.
- R6: A read then drives `mdio_oe`=0 and `mdio_o`=0 for 19 bits. It samples `mdio_i` on the last low cycle of each bit (the edge at which `mdc` rises). If the first sample is the most significant bit of a 19-bit word C, the result is C[16:1].
- R7: A write sends 32 bits after the preamble, most significant first, with `mdio_oe`=1: 0,1,0,1, PHY address[4:0], register address[4:0], 1,0, data[15:0].
- R8: The cycle after the last bit has `done`=1, `busy`=1, `mdc`=0 and `mdio_oe`=0. In the following cycle `busy`=0. `rd_data` takes the read result in the done cycle of a read, and a write leaves it unchanged.
- R9: `mdio_o` and `mdio_oe` change only at bit starts, so they stay constant while `mdc` is high.
- R10: While `busy` is low, `mdc`=0 and `mdio_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_regad | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output-enable |
| mdio_i | input | 1 | Data line input from pad |

## Verification
Two functions can land in the same cycle: the done pulse that ends a transaction, and the arrival of a new request. The bench provokes this by holding `req_valid` high from one transaction straight through its done cycle. The request must be refused during done, accepted on the idle cycle that follows, and the second frame must start exactly one cycle later. A behavioural model holds the expected wire bits in a queue and judges every cycle. That includes the read result, which is built from a 19-bit pattern whose edge bits differ from its middle bits, so that an off-by-one sample would show.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W    = 5;
    localparam int REGAD_W  = 5;
    localparam int DAT_W    = 16;
    localparam int PRE_BITS = 33;   // ones sent before every frame
    localparam int HDR_BITS = 16;   // read header length
    localparam int CAP_BITS = 19;   // bits clocked in during a read
    localparam int FRM_BITS = 32;   // write frame length
    localparam int BIT_W    = $clog2(PRE_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_CAPTURE,
        ST_FRAME,
        ST_DONE
    } mdio_state_t;

    // Read header, left-aligned in a frame-wide word
    function automatic logic [FRM_BITS-1:0] read_header(
        input logic [PHY_W-1:0]   phy,
        input logic [REGAD_W-1:0] regad
    );
        return {6'b110110, phy, regad, {(FRM_BITS-HDR_BITS){1'b0}}};
    endfunction

    function automatic logic [FRM_BITS-1:0] write_frame(
        input logic [PHY_W-1:0]   phy,
        input logic [REGAD_W-1:0] regad,
        input logic [DAT_W-1:0]   data
    );
        return {4'b0101, phy, regad, 2'b10, data};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_HALF = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_next,
    output logic bit_end
);
    localparam int PERIOD = 2 * DIV_HALF;
    localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    assign rise_next = run && (cnt_q == CW'(DIV_HALF - 1));
    assign bit_end   = run && (cnt_q == CW'(PERIOD - 1));

    always_comb begin
        if (!run || bit_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            mdc   <= run && (cnt_d >= CW'(DIV_HALF));
        end
    end
endmodule

// File: rtl/mdio_shift.sv
module mdio_shift
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [FRM_BITS-1:0] load_word,
    input  logic                shift_en,
    output logic                tx_bit,
    input  logic                cap_en,
    input  logic                cap_bit,
    input  logic                rd_load,
    output logic [DAT_W-1:0]    rd_data
);
    logic [FRM_BITS-1:0] tx_q;
    logic [CAP_BITS-1:0] cap_q;

    assign tx_bit = tx_q[FRM_BITS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            cap_q   <= '0;
            rd_data <= '0;
        end else begin
            if (load) begin
                tx_q <= load_word;
            end else if (shift_en) begin
                tx_q <= {tx_q[FRM_BITS-2:0], 1'b0};
            end
            if (cap_en) begin
                cap_q <= {cap_q[CAP_BITS-2:0], cap_bit};
            end
            if (rd_load) begin
                rd_data <= cap_q[DAT_W:1];
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [PHY_W-1:0]   req_phy,
    input  logic [REGAD_W-1:0] req_regad,
    input  logic [DAT_W-1:0]   req_wdata,
    output logic               busy,
    output logic               done,
    output logic [DAT_W-1:0]   rd_data,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    mdio_state_t         state_q, state_d;
    logic [BIT_W-1:0]    bit_q, bit_d;
    logic                wr_q;
    logic                accept;
    logic                seg_done;
    logic                timer_run;
    logic                rise_next;
    logic                bit_end;
    logic                tx_bit;
    logic                shift_en;
    logic                cap_en;
    logic                rd_load;
    logic [FRM_BITS-1:0] load_word;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign load_word = req_write ? write_frame(req_phy, req_regad, req_wdata)
                                 : read_header(req_phy, req_regad);

    // last bit of the current segment
    always_comb begin
        unique case (state_q)
            ST_PREAMBLE: seg_done = (bit_q == BIT_W'(PRE_BITS - 1));
            ST_HEADER:   seg_done = (bit_q == BIT_W'(HDR_BITS - 1));
            ST_CAPTURE:  seg_done = (bit_q == BIT_W'(CAP_BITS - 1));
            ST_FRAME:    seg_done = (bit_q == BIT_W'(FRM_BITS - 1));
            default:     seg_done = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_PREAMBLE;
                    bit_d   = '0;
                end
            end
            ST_PREAMBLE, ST_HEADER, ST_CAPTURE, ST_FRAME: begin
                if (bit_end) begin
                    if (seg_done) begin
                        bit_d = '0;
                        unique case (state_q)
                            ST_PREAMBLE: state_d = wr_q ? ST_FRAME : ST_HEADER;
                            ST_HEADER:   state_d = ST_CAPTURE;
                            default:     state_d = ST_DONE;
                        endcase
                    end else begin
                        bit_d = bit_q + BIT_W'(1);
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            if (accept) begin
                wr_q <= req_write;
            end
        end
    end

    // outputs and datapath controls
    always_comb begin
        busy      = 1'b1;
        done      = 1'b0;
        timer_run = 1'b0;
        mdio_oe   = 1'b0;
        mdio_o    = 1'b0;
        shift_en  = 1'b0;
        cap_en    = 1'b0;
        rd_load   = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_PREAMBLE: begin
                timer_run = 1'b1;
                mdio_oe   = 1'b1;
                mdio_o    = 1'b1;
            end
            ST_HEADER, ST_FRAME: begin
                timer_run = 1'b1;
                mdio_oe   = 1'b1;
                mdio_o    = tx_bit;
                shift_en  = bit_end;
            end
            ST_CAPTURE: begin
                timer_run = 1'b1;
                cap_en    = rise_next;
                rd_load   = bit_end && seg_done;
            end
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    mdio_mdc_gen #(
        .DIV_HALF (DIV_HALF)
    ) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (timer_run),
        .mdc       (mdc),
        .rise_next (rise_next),
        .bit_end   (bit_end)
    );

    mdio_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (load_word),
        .shift_en  (shift_en),
        .tx_bit    (tx_bit),
        .cap_en    (cap_en),
        .cap_bit   (mdio_i),
        .rd_load   (rd_load),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DIV_HALF = 25
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (mdc) begin
            hi_cnt <= hi_cnt + 16'd1;
        end else begin
            hi_cnt <= '0;
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R3
    high_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_cnt == 16'(DIV_HALF)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !mdc && !mdio_oe));

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R9
    stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_master mdio_master_chk #(
    .DIV_HALF (DIV_HALF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_regad = '0;
    logic [15:0] req_wdata = '0;
    logic        mdio_i = 1'b1;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mdio_master #(.DIV_HALF(H)) uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_write (req_write), .req_phy (req_phy), .req_regad (req_regad),
        .req_wdata (req_wdata), .busy (busy), .done (done),
        .rd_data (rd_data), .mdc (mdc), .mdio_o (mdio_o),
        .mdio_oe (mdio_oe), .mdio_i (mdio_i)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_active = 0;
    bit          m_done = 0;
    bit          m_wr = 0;
    int          m_k = 0;
    int          m_nbits = 0;
    bit          m_drv[$];
    bit          m_val[$];
    logic [18:0] m_cap = '0;
    logic [18:0] m_pat = '0;
    logic [18:0] cur_pat = '0;
    logic [15:0] m_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_done = 0; m_k = 0; m_rd = '0;
        end else if (m_done) begin
            m_done = 0;
        end else if (m_active) begin
            int b;
            int ph;
            b  = m_k / (2 * H);
            ph = m_k % (2 * H);
            if (!m_wr && b >= 49 && ph == H - 1) m_cap = {m_cap[17:0], mdio_i};
            m_k++;
            if (m_k == 2 * H * m_nbits) begin
                m_active = 0;
                m_done = 1;
                if (!m_wr) m_rd = m_cap[16:1];
            end
        end else if (req_valid) begin
            logic [31:0] w;
            m_drv.delete();
            m_val.delete();
            for (int i = 0; i < 33; i++) begin m_drv.push_back(1); m_val.push_back(1); end
            m_wr  = req_write;
            m_pat = cur_pat;
            if (req_write) begin
                w = {2'b01, 2'b01, req_phy, req_regad, 2'b10, req_wdata};
                for (int i = 31; i >= 0; i--) begin m_drv.push_back(1); m_val.push_back(w[i]); end
            end else begin
                w = {16'h0, 2'b11, 2'b01, 2'b10, req_phy, req_regad};
                for (int i = 15; i >= 0; i--) begin m_drv.push_back(1); m_val.push_back(w[i]); end
                for (int i = 0; i < 19; i++) begin m_drv.push_back(0); m_val.push_back(0); end
            end
            m_nbits  = m_drv.size();
            m_k      = 0;
            m_active = 1;
        end
    end

    // compare every cycle and drive the PHY side
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int b;
            bit e_mdc, e_oe, e_o, e_busy;
            string tag;
            b      = m_k / (2 * H);
            e_busy = m_active || m_done;
            e_mdc  = m_active && ((m_k % (2 * H)) >= H);
            e_oe   = m_active && m_drv[b];
            e_o    = m_active && m_drv[b] && m_val[b];
            if (!e_busy)       tag = "R10";
            else if (e_mdc)    tag = "R9";
            else if (!m_active) tag = "R8";
            else if (b < 33)   tag = "R4";
            else if (m_wr)     tag = "R7";
            else if (b < 49)   tag = "R5";
            else               tag = "R6";
            chk("R2", "busy", 32'(busy), 32'(e_busy));
            chk("R8", "done", 32'(done), 32'(m_done));
            chk("R3", "mdc", 32'(mdc), 32'(e_mdc));
            chk(tag, "mdio_oe", 32'(mdio_oe), 32'(e_oe));
            chk(tag, "mdio_o", 32'(mdio_o), 32'(e_o));
            chk("R6", "rd_data", 32'(rd_data), 32'(m_rd));
            if (m_active && !m_wr && b >= 49) mdio_i = m_pat[18 - (b - 49)];
            else mdio_i = 1'b1;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] d, input logic [18:0] pat);
        @(negedge clk);
        while (busy) @(negedge clk);
        cur_pat   = pat;
        req_valid = 1'b1;
        req_write = wr;
        req_phy   = phy;
        req_regad = ra;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "mdc", 32'(mdc), 0);
        chk("R1", "mdio_oe", 32'(mdio_oe), 0);
        chk("R1", "mdio_o", 32'(mdio_o), 0);
        chk("R1", "rd_data", 32'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after release", 32'(busy), 0);

        // R7: writes with extreme fields
        issue(1, 5'h00, 5'h00, 16'h0000, '0); wait_idle();
        issue(1, 5'h1F, 5'h1F, 16'hFFFF, '0); wait_idle();
        // R5/R6: reads with edge-bit patterns
        issue(0, 5'h15, 5'h0A, 16'h0000, 19'h40001); wait_idle();
        issue(0, 5'h01, 5'h02, 16'h0000, 19'h3FFFE); wait_idle();
        issue(0, 5'h0E, 5'h11, 16'h0000, 19'h2A5A6); wait_idle();

        // R2: junk requests while busy are ignored
        issue(1, 5'h1A, 5'h05, 16'hA55A, '0);
        req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h03; req_regad = 5'h1C;
        req_wdata = 16'h1234;
        repeat (150) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        // R8: write leaves rd_data unchanged (model compares every cycle)

        // R2/R8: request held through done, second frame starts on idle cycle
        cur_pat = 19'h7FFFF;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h09; req_regad = 5'h16;
        while (!done) @(negedge clk);
        req_write = 1'b1; req_phy = 5'h12; req_regad = 5'h0D; req_wdata = 16'h5AC3;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        issue(0, 5'h07, 5'h1E, 16'h0000, 19'h1B3C9); wait_idle();
        repeat (5) @(negedge clk);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected idle");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule